// File: doc/BRIEF.md
# Countdown Alarm Output Controller

This block owns one general-purpose output pin and a single 32-bit control word that is written through a simple register port. The control word packs a mode field, a target pin level and a 20-bit seconds count. In force mode a write sets the pin to the target level at once. In timed mode the count runs down on a one-second tick. When the count expires, the target level goes onto the pin and a sticky status flag is raised.

The count is loaded as the wanted number of seconds minus one, so delays from 1 to 2^20 seconds are possible. Software normally moves the pin to the opposite level in force mode first, and then arms a timed write. The flag tells software that the timed level has taken effect. Writing force mode with the level bit set (0x500000) returns the pin to its idle high level and clears the flag.

Top module: `alarm_gpo_timer`

## Requirements
- R1: While reset is active and after it is released, before any write, the pin equals parameter IDLE_LVL (default 1) and the readback word is zero.
- R2: After a write, the readback word holds the written count in bits 19:0, the mode in bits 21:20 and the level in bit 22. Bit 24 is the status flag. Bit 23 and bits 31:25 read as zero, whatever value was written to them.
- R3: A write with mode 1 sets the pin to the written bit 22 value on the clock edge that accepts the write.
- R4: In mode 2, while the flag is clear, each tick cycle with no write and a nonzero count lowers the count by one and leaves the pin unchanged.
- R5: In mode 2, a count loaded as N-1 makes the pin take the bit 22 level on the Nth tick, and bit 24 goes to 1 on the same edge.
- R6: Once the flag is set, further ticks change neither the count nor the pin, and the flag stays set until the next write.
- R7: Every write reloads the count from the written data and clears bit 24.
- R8: In modes 0, 1 and 3, ticks leave both the count and the pin unchanged.
- R9: When a write and a tick fall in the same cycle, the write takes effect and that tick does not decrement the newly loaded count.
- R10: A mode 2 write with a count of zero fires on the first tick that follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe for the control word |
| wr_data_i | input | 32 | Control word data |
| sec_tick_i | input | 1 | One-cycle pulse once per second |
| rd_data_o | output | 32 | Readback: live count, mode, level, status flag |
| pin_o | output | 1 | Output pin level |

## Verification
The hardest cases to reach from the ports are the edges where one count boundary meets another event: a write that lands in the same cycle as a tick, the tick that finds the count already at zero, and ticks that arrive after the alarm has fired. The bench drives tick and write strobes cycle by cycle. It places a write directly on a tick, loads a zero count, and keeps ticking after expiry. A reference model of the register tracks the expected count, flag and pin after every cycle.

// File: rtl/alarm_pkg.sv
`timescale 1ns/1ps
package alarm_pkg;
  parameter int unsigned DATA_W   = 32;
  parameter int unsigned CNT_W    = 20;
  parameter int unsigned MODE_W   = 2;
  parameter int unsigned MODE_LSB = CNT_W;
  parameter int unsigned LVL_BIT  = MODE_LSB + MODE_W;
  parameter int unsigned FLAG_BIT = LVL_BIT + 2;

  typedef enum logic [MODE_W-1:0] {
    MODE_HOLD   = 2'd0,
    MODE_FORCE  = 2'd1,
    MODE_TIMED  = 2'd2,
    MODE_HOLD_B = 2'd3
  } alarm_mode_e;
endpackage

// File: rtl/alarm_cfg_reg.sv
`timescale 1ns/1ps
module alarm_cfg_reg
  import alarm_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  alarm_mode_e wr_mode_i,
  input  logic        wr_lvl_i,
  output alarm_mode_e mode_o,
  output logic        lvl_o,
  output logic        force_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o <= MODE_HOLD;
      lvl_o  <= 1'b0;
    end else if (wr_en_i) begin
      mode_o <= wr_mode_i;
      lvl_o  <= wr_lvl_i;
    end
  end

  assign force_o = wr_en_i && (wr_mode_i == MODE_FORCE);
endmodule

// File: rtl/alarm_counter.sv
`timescale 1ns/1ps
module alarm_counter #(
  parameter int unsigned W = 20
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         dec_i,
  output logic [W-1:0] cnt_o,
  output logic         zero_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (load_i) cnt_o <= load_val_i;
    else if (dec_i)  cnt_o <= cnt_o - W'(1);
  end

  assign zero_o = (cnt_o == '0);
endmodule

// File: rtl/alarm_output.sv
`timescale 1ns/1ps
module alarm_output #(
  parameter logic IDLE_LVL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  logic force_i,
  input  logic force_lvl_i,
  input  logic fire_i,
  input  logic fire_lvl_i,
  output logic pin_o,
  output logic fired_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pin_o <= IDLE_LVL;
    else if (force_i) pin_o <= force_lvl_i;
    else if (fire_i)  pin_o <= fire_lvl_i;
  end

  // sticky until any write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     fired_o <= 1'b0;
    else if (wr_i)   fired_o <= 1'b0;
    else if (fire_i) fired_o <= 1'b1;
  end
endmodule

// File: rtl/alarm_gpo_timer.sv
`timescale 1ns/1ps
module alarm_gpo_timer
  import alarm_pkg::*;
#(
  parameter logic IDLE_LVL = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              sec_tick_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              pin_o
);
  alarm_mode_e      mode;
  logic             lvl, force_wr, fired, cnt_zero, run, fire, dec;
  logic [CNT_W-1:0] cnt;
  logic             unused_wr_bits;

  assign unused_wr_bits = ^wr_data_i[DATA_W-1:LVL_BIT+1];

  alarm_cfg_reg i_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_mode_i (alarm_mode_e'(wr_data_i[MODE_LSB +: MODE_W])),
    .wr_lvl_i  (wr_data_i[LVL_BIT]),
    .mode_o    (mode),
    .lvl_o     (lvl),
    .force_o   (force_wr)
  );

  // a write in the same cycle masks the tick
  assign run  = !wr_en_i && sec_tick_i && (mode == MODE_TIMED) && !fired;
  assign fire = run && cnt_zero;
  assign dec  = run && !cnt_zero;

  alarm_counter #(.W(CNT_W)) i_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (wr_en_i),
    .load_val_i (wr_data_i[CNT_W-1:0]),
    .dec_i      (dec),
    .cnt_o      (cnt),
    .zero_o     (cnt_zero)
  );

  alarm_output #(.IDLE_LVL(IDLE_LVL)) i_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (wr_en_i),
    .force_i     (force_wr),
    .force_lvl_i (wr_data_i[LVL_BIT]),
    .fire_i      (fire),
    .fire_lvl_i  (lvl),
    .pin_o       (pin_o),
    .fired_o     (fired)
  );

  always_comb begin
    rd_data_o                       = '0;
    rd_data_o[CNT_W-1:0]            = cnt;
    rd_data_o[MODE_LSB +: MODE_W]   = mode;
    rd_data_o[LVL_BIT]              = lvl;
    rd_data_o[FLAG_BIT]             = fired;
  end
endmodule

// File: rtl/alarm_gpo_timer_chk.sv
`timescale 1ns/1ps
module alarm_gpo_timer_chk
  import alarm_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic              sec_tick_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              pin_o
);
  logic             flag, armed;
  logic [CNT_W-1:0] cnt;
  logic             unused_chk;

  assign flag  = rd_data_o[FLAG_BIT];
  assign cnt   = rd_data_o[CNT_W-1:0];
  assign armed = (rd_data_o[MODE_LSB +: MODE_W] == MODE_TIMED) && !flag;
  assign unused_chk = ^wr_data_i[DATA_W-1:LVL_BIT+1];

  a_r2_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o[LVL_BIT+1] == 1'b0) && (rd_data_o[DATA_W-1:FLAG_BIT+1] == '0));

  a_r3_force_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && (wr_data_i[MODE_LSB +: MODE_W] == MODE_FORCE)
    |=> pin_o == $past(wr_data_i[LVL_BIT]));

  a_r4_decrement: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i && sec_tick_i && armed && (cnt != '0)
    |=> (cnt == $past(cnt) - CNT_W'(1)) && $stable(pin_o) && !flag);

  a_r5_fire: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i && sec_tick_i && armed && (cnt == '0)
    |=> flag && (pin_o == $past(rd_data_o[LVL_BIT])));

  a_r6_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag && !wr_en_i |=> flag && $stable(pin_o) && $stable(cnt));

  a_r7_write_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> !flag && (cnt == $past(wr_data_i[CNT_W-1:0])));

  a_r8_hold_other_modes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i && (rd_data_o[MODE_LSB +: MODE_W] != MODE_TIMED)
    |=> $stable(pin_o) && $stable(cnt));
endmodule

bind alarm_gpo_timer alarm_gpo_timer_chk i_alarm_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .wr_data_i  (wr_data_i),
  .sec_tick_i (sec_tick_i),
  .rd_data_o  (rd_data_o),
  .pin_o      (pin_o)
);

// File: tb/test_alarm_gpo_timer.sv
`timescale 1ns/1ps
module test_alarm_gpo_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        tick = 1'b0;
  logic [31:0] rd_data;
  logic        pin;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic        pin;
    logic [31:0] rd;
    string       tag;
  } exp_t;
  exp_t exp_q[$];

  // reference model state
  logic [19:0] m_cnt = '0;
  logic [1:0]  m_mode = '0;
  logic        m_lvl = 1'b0;
  logic        m_flag = 1'b0;
  logic        m_pin = 1'b1;

  always #10 clk = ~clk;

  alarm_gpo_timer i_alarm_gpo_timer (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .wr_en_i    (wr_en),
    .wr_data_i  (wr_data),
    .sec_tick_i (tick),
    .rd_data_o  (rd_data),
    .pin_o      (pin)
  );

  task automatic cyc(input logic w, input logic [31:0] d, input logic t, input string tag);
    exp_t e;
    @(negedge clk);
    wr_en = w; wr_data = d; tick = t;
    if (w) begin
      m_cnt = d[19:0]; m_mode = d[21:20]; m_lvl = d[22]; m_flag = 1'b0;
      if (d[21:20] == 2'd1) m_pin = d[22];
    end else if (t && m_mode == 2'd2 && !m_flag) begin
      if (m_cnt == 20'd0) begin m_pin = m_lvl; m_flag = 1'b1; end
      else m_cnt = m_cnt - 20'd1;
    end
    e.pin = m_pin;
    e.rd  = {7'b0, m_flag, 1'b0, m_lvl, m_mode, m_cnt};
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic ticks(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      cyc(1'b0, 32'h0, 1'b1, tag);
      cyc(1'b0, 32'h0, 1'b0, tag);
    end
  endtask

  // monitor: compares after each edge
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      checks++;
      if (pin !== e.pin || rd_data !== e.rd) begin
        errors++;
        $display("FAIL %s: pin=%0b rd=%08h expected pin=%0b rd=%08h",
                 e.tag, pin, rd_data, e.pin, e.rd);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (pin !== 1'b1 || rd_data !== 32'h0) begin
      errors++;
      $display("FAIL R1 in reset: pin=%0b rd=%08h expected pin=1 rd=00000000", pin, rd_data);
    end
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (pin !== 1'b1 || rd_data !== 32'h0) begin
      errors++;
      $display("FAIL R1 after reset: pin=%0b rd=%08h expected pin=1 rd=00000000", pin, rd_data);
    end
    ticks(2, "R8 ticks in reset mode 0");

    // R3 force low, then back to idle high
    cyc(1'b1, 32'h0010_0000, 1'b0, "R3 force low");
    ticks(2, "R8 mode 1 ignores ticks");
    cyc(1'b1, 32'h0050_0000, 1'b0, "R3 force high");

    // R4/R5 arm: opposite level first, then 3-second timed high
    cyc(1'b1, 32'h0010_0000, 1'b0, "R3 pre-arm low");
    cyc(1'b1, 32'h0060_0002, 1'b0, "R7 load timed");
    cyc(1'b0, 32'h0, 1'b0, "R4 idle no tick");
    ticks(2, "R4 decrement");
    ticks(1, "R5 fire on third tick");
    ticks(3, "R6 after fire");

    // R7 clear
    cyc(1'b1, 32'h0050_0000, 1'b0, "R7 clear flag");

    // R10 zero count
    cyc(1'b1, 32'h0020_0000, 1'b0, "R10 timed low zero count");
    ticks(1, "R10 fire first tick");
    ticks(1, "R6 sticky");

    // R9 write with tick
    cyc(1'b1, 32'h0050_0000, 1'b0, "R3 idle");
    cyc(1'b1, 32'h0020_0005, 1'b1, "R9 write beats tick");
    cyc(1'b0, 32'h0, 1'b0, "R9 hold");
    ticks(2, "R4 timed low");
    cyc(1'b1, 32'h0020_0001, 1'b1, "R9 reload during tick");
    ticks(2, "R5 fire low");
    cyc(1'b1, 32'h0060_0004, 1'b1, "R7 rewrite after fire with tick");

    // R8 modes 0 and 3
    cyc(1'b1, 32'h0000_0003, 1'b0, "R8 mode 0");
    ticks(3, "R8 mode 0 ticks");
    cyc(1'b1, 32'h0070_0007, 1'b0, "R8 mode 3");
    ticks(3, "R8 mode 3 ticks");

    // R2 reserved bits
    cyc(1'b1, 32'hFFFF_FFFF, 1'b0, "R2 all ones write");
    cyc(1'b1, 32'hFF80_0000, 1'b0, "R2 reserved only");

    // large count
    cyc(1'b1, 32'h006F_FFFF, 1'b0, "R7 max count");
    ticks(3, "R4 max count decrement");
    cyc(1'b1, 32'h0050_0000, 1'b0, "R7 final clear");
    cyc(1'b0, 32'h0, 1'b0, "R6 idle end");
    repeat (3) @(negedge clk);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule